// File: doc/BRIEF.md
# I2C Tag Stream Builder

This block converts one I2C transfer request into the byte stream that a tagged I2C command decoder consumes. The request carries a seven- or ten-bit target address, a read flag, a ten-bit flag and a byte length from 1 to 65535. Writes also supply payload bytes on a byte input stream. The message is cut into blocks of at most 256 bytes. For each block the builder emits that block's command tags. For a write, the block's payload bytes follow the tags. Every byte is packed little-endian into 32-bit words on a valid/ready output port.

When a request is accepted, the builder reports how many entries the engine must shift out, tags included. After each block's words have left, it waits for a per-block completion pulse from the bus engine before it builds the next block. If that pulse does not arrive within a programmable number of cycles, the builder gives up and returns to idle.

Top module: `i2c_tag_streamer`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `out_valid`, `din_ready` and `busy` are 0.
- R2: A request with length 0 is refused. `len_err` pulses in the cycle after acceptance, no entry count is reported, no word is produced and the block stays idle.
- R3: The cycle after a non-zero request is accepted, `entry_cnt_valid` pulses with `entry_cnt` = length + 4 + 2*(blocks-1). Blocks = ceil(length/256). The ten-bit flag does not change this count.
- R4: The first block opens with byte 0x81. Next comes the low byte of A = (address << 1) | read flag. When the ten-bit flag is set, a byte holding A >> 8 follows. Later blocks carry no start or address bytes.
- R5: Each block carries one data tag and then a length byte. For the final block the data tag is 0x87 (read) or 0x83 (write). For any earlier block it is 0x85 (read) or 0x82 (write).
- R6: A block's length byte equals min(256, remaining bytes), and the value 256 is written as 0x00.
- R7: For a write, exactly the block's length in payload bytes follows the tags and is taken from `din_byte`. For a read, no payload is emitted and `din_ready` never rises.
- R8: Bytes are packed four per word, with the earliest byte in bits 7:0. Each block's stream ends in its own word, and any unused upper bytes of that word are zero.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: After a block's last word, no further word is produced until `blk_done` arrives. A `blk_done` seen while the block is still being emitted is ignored. After the final block's `blk_done`, `xfer_done` pulses and the block returns to idle.
- R11: A block waits for `blk_done` for `tmo_limit`+1 cycles. If it has not arrived by then, `timeout` pulses and the block returns to idle. A `blk_done` arriving later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 10 | Target address |
| req_rd | input | 1 | 1 = read transfer |
| req_ten | input | 1 | 1 = ten-bit address |
| req_len | input | LEN_W | Byte length of the message |
| din_valid | input | 1 | Write payload byte present |
| din_byte | input | 8 | Write payload byte |
| din_ready | output | 1 | Payload byte taken this cycle |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Packed output word |
| out_ready | input | 1 | Consumer takes the word |
| entry_cnt | output | LEN_W+1 | Total entries to shift out |
| entry_cnt_valid | output | 1 | One-cycle strobe for entry_cnt |
| blk_done | input | 1 | Bus engine finished the current block |
| tmo_limit | input | TMO_W | Completion wait limit in cycles |
| busy | output | 1 | A transfer is in progress |
| xfer_done | output | 1 | Pulse when the final block completes |
| len_err | output | 1 | Pulse on a zero-length request |
| timeout | output | 1 | Pulse when a completion wait expires |

## Verification
A wrong block counter or a wrong remaining-length register shows up in the tag bytes of the very next block. The data tag would pick the stop variant too early or too late, or the length byte would be off. The bench compares every word against a model built from the requirements, so such errors are caught within a few cycles. A packer whose byte slot drifts scrambles bytes within the same word. A missed flush leaves the block with one word fewer than expected and the transfer hangs. If the wait state is left too early, words appear before `blk_done`. The bench watches for these in the idle cycles it inserts between blocks.

// File: rtl/tsb_pkg.sv
// Package: shared tag codes and controller states for the tag stream builder.
// Assumes byte-wide tags and 32-bit output words.
package tsb_pkg;
    localparam logic [7:0] TAG_OPEN      = 8'h81;
    localparam logic [7:0] TAG_WR_MORE   = 8'h82;
    localparam logic [7:0] TAG_WR_FINAL  = 8'h83;
    localparam logic [7:0] TAG_RD_MORE   = 8'h85;
    localparam logic [7:0] TAG_RD_FINAL  = 8'h87;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TAGS  = 3'd1,
        ST_DATA  = 3'd2,
        ST_FLUSH = 3'd3,
        ST_WAIT  = 3'd4
    } tsb_state_e;
endpackage

// File: rtl/tsb_tag_seq.sv
// Tag sequencer: given the block context, returns the tag byte at a position
// and the number of tag bytes in this block. Purely combinational.
// Assumes idx < cnt whenever the caller uses tag_byte.
module tsb_tag_seq
    import tsb_pkg::*;
(
    input  logic       first,
    input  logic       ten,
    input  logic       rd,
    input  logic       last,
    input  logic [7:0] addr_lo,
    input  logic [7:0] addr_hi,
    input  logic [7:0] len_byte,
    input  logic [2:0] idx,
    output logic [7:0] tag_byte,
    output logic [2:0] tag_cnt
);
    logic [7:0] seq [8];
    logic [7:0] dtag;

    // Select the data tag from direction and last-block flag.
    always_comb begin
        if (rd) dtag = last ? TAG_RD_FINAL : TAG_RD_MORE;
        else    dtag = last ? TAG_WR_FINAL : TAG_WR_MORE;
    end

    // Lay out the tag list for this block.
    always_comb begin
        for (int i = 0; i < 8; i++) seq[i] = 8'h00;
        if (first && ten) begin
            seq[0] = TAG_OPEN; seq[1] = addr_lo; seq[2] = addr_hi;
            seq[3] = dtag;     seq[4] = len_byte;
            tag_cnt = 3'd5;
        end else if (first) begin
            seq[0] = TAG_OPEN; seq[1] = addr_lo;
            seq[2] = dtag;     seq[3] = len_byte;
            tag_cnt = 3'd4;
        end else begin
            seq[0] = dtag; seq[1] = len_byte;
            tag_cnt = 3'd2;
        end
        tag_byte = seq[idx];
    end
endmodule

// File: rtl/tsb_packer.sv
// Byte packer: collects bytes little-endian into 32-bit words, holding one
// finished word in an output register with valid/ready. A flush request
// emits a partial word with zero upper bytes. Assumes flush is only raised
// when no more bytes are offered for the current block.
module tsb_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        b_valid,
    input  logic [7:0]  b_data,
    output logic        b_ready,
    input  logic        flush,
    output logic        empty,
    output logic        out_valid,
    output logic [31:0] out_data,
    input  logic        out_ready
);
    logic [31:0] acc_q;
    logic [1:0]  cnt_q;
    logic        slot_free;

    assign slot_free = !out_valid || out_ready;
    assign b_ready   = slot_free;
    assign empty     = (cnt_q == 2'd0) && !out_valid;

    // Accumulate bytes and move full or flushed words to the output slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (b_valid && slot_free) begin
                if (cnt_q == 2'd3) begin
                    out_data  <= {b_data, acc_q[23:0]};
                    out_valid <= 1'b1;
                    acc_q     <= '0;
                    cnt_q     <= '0;
                end else begin
                    acc_q[8*cnt_q +: 8] <= b_data;
                    cnt_q <= cnt_q + 2'd1;
                end
            end else if (flush && cnt_q != 2'd0 && slot_free) begin
                out_data  <= acc_q;
                out_valid <= 1'b1;
                acc_q     <= '0;
                cnt_q     <= '0;
            end
        end
    end

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_flush_no_extra_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && empty) |=> !out_valid);
endmodule

// File: rtl/tsb_wait_timer.sv
// Completion wait timer: counts cycles while run is high and flags hit on
// the cycle the count reaches limit. Clears whenever run is low.
module tsb_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = run && (cnt_q == limit);

    // Count waiting cycles, restart when not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (!hit)   cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/i2c_tag_streamer.sv
// I2C tag stream builder top. Accepts a transfer request, splits it into
// blocks of 2**BLK_LOG2 bytes, emits per-block tags (and write payload)
// through the packer, and waits for blk_done between blocks with a timeout.
// Assumes BLK_LOG2 <= 8 and LEN_W > BLK_LOG2.
module i2c_tag_streamer
    import tsb_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int BLK_LOG2 = 8,
    parameter int TMO_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [9:0]         req_addr,
    input  logic               req_rd,
    input  logic               req_ten,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               din_valid,
    input  logic [7:0]         din_byte,
    output logic               din_ready,
    output logic               out_valid,
    output logic [31:0]        out_data,
    input  logic               out_ready,
    output logic [LEN_W:0]     entry_cnt,
    output logic               entry_cnt_valid,
    input  logic               blk_done,
    input  logic [TMO_W-1:0]   tmo_limit,
    output logic               busy,
    output logic               xfer_done,
    output logic               len_err,
    output logic               timeout
);
    localparam int CNT_W     = LEN_W + 1;
    localparam int BLK_BYTES = 1 << BLK_LOG2;

    tsb_state_e           state_q;
    logic [9:0]           addr_q;
    logic                 rd_q, ten_q, first_q;
    logic [LEN_W-1:0]     rem_q;
    logic [2:0]           tidx_q;
    logic [BLK_LOG2:0]    bleft_q;

    logic                 is_last;
    logic [BLK_LOG2:0]    blen;
    logic [7:0]           len_byte, tag_byte;
    logic [2:0]           tag_cnt;
    logic [10:0]          addr_full;
    logic [CNT_W-1:0]     len_ext, nblk_c, entry_c;
    logic                 pk_valid, pk_ready, pk_empty, tmo_hit;
    logic [7:0]           pk_data;

    // Block size and encoded length byte from the remaining count.
    always_comb begin
        is_last  = (rem_q <= LEN_W'(BLK_BYTES));
        blen     = is_last ? rem_q[BLK_LOG2:0] : (BLK_LOG2+1)'(BLK_BYTES);
        len_byte = 8'(blen[BLK_LOG2-1:0]);
    end

    // Entry count for a new request: length plus transmit tag bytes.
    always_comb begin
        len_ext = CNT_W'(req_len);
        nblk_c  = (len_ext + CNT_W'(BLK_BYTES - 1)) >> BLK_LOG2;
        entry_c = len_ext + (nblk_c << 1) + CNT_W'(2);
    end

    assign addr_full = {addr_q, rd_q};

    tsb_tag_seq i_tag_seq (
        .first    (first_q),
        .ten      (ten_q),
        .rd       (rd_q),
        .last     (is_last),
        .addr_lo  (addr_full[7:0]),
        .addr_hi  ({5'b0, addr_full[10:8]}),
        .len_byte (len_byte),
        .idx      (tidx_q),
        .tag_byte (tag_byte),
        .tag_cnt  (tag_cnt)
    );

    // Byte source for the packer: tags, or payload during a write block.
    always_comb begin
        pk_valid = (state_q == ST_TAGS) || (state_q == ST_DATA && din_valid);
        pk_data  = (state_q == ST_DATA) ? din_byte : tag_byte;
    end

    assign din_ready = (state_q == ST_DATA) && pk_ready;
    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);

    tsb_packer i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .b_valid   (pk_valid),
        .b_data    (pk_data),
        .b_ready   (pk_ready),
        .flush     (state_q == ST_FLUSH),
        .empty     (pk_empty),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    tsb_wait_timer #(.W(TMO_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_WAIT),
        .limit (tmo_limit),
        .hit   (tmo_hit)
    );

    // Transfer sequencing: request, tags, payload, flush, completion wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= ST_IDLE;
            addr_q          <= '0;
            rd_q            <= 1'b0;
            ten_q           <= 1'b0;
            first_q         <= 1'b0;
            rem_q           <= '0;
            tidx_q          <= '0;
            bleft_q         <= '0;
            entry_cnt       <= '0;
            entry_cnt_valid <= 1'b0;
            xfer_done       <= 1'b0;
            len_err         <= 1'b0;
            timeout         <= 1'b0;
        end else begin
            entry_cnt_valid <= 1'b0;
            xfer_done       <= 1'b0;
            len_err         <= 1'b0;
            timeout         <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    if (req_len == '0) begin
                        len_err <= 1'b1;
                    end else begin
                        addr_q          <= req_addr;
                        rd_q            <= req_rd;
                        ten_q           <= req_ten;
                        rem_q           <= req_len;
                        first_q         <= 1'b1;
                        tidx_q          <= '0;
                        entry_cnt       <= entry_c;
                        entry_cnt_valid <= 1'b1;
                        state_q         <= ST_TAGS;
                    end
                end
                ST_TAGS: if (pk_ready) begin
                    if (tidx_q == tag_cnt - 3'd1) begin
                        tidx_q  <= '0;
                        bleft_q <= blen;
                        state_q <= rd_q ? ST_FLUSH : ST_DATA;
                    end else begin
                        tidx_q <= tidx_q + 3'd1;
                    end
                end
                ST_DATA: if (din_valid && pk_ready) begin
                    bleft_q <= bleft_q - (BLK_LOG2+1)'(1);
                    if (bleft_q == (BLK_LOG2+1)'(1)) state_q <= ST_FLUSH;
                end
                ST_FLUSH: if (pk_empty) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (blk_done) begin
                        if (is_last) begin
                            xfer_done <= 1'b1;
                            state_q   <= ST_IDLE;
                        end else begin
                            rem_q   <= rem_q - LEN_W'(blen);
                            first_q <= 1'b0;
                            state_q <= ST_TAGS;
                        end
                    end else if (tmo_hit) begin
                        timeout <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !out_valid);

    p_zero_len_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (state_q == ST_IDLE && !entry_cnt_valid));

    p_count_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_cnt_valid |-> (state_q == ST_TAGS && first_q && tidx_q == 3'd0));

    p_din_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> !rd_q);

    p_busy_has_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q != '0));

    p_done_after_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ($past(state_q) == ST_WAIT && $past(blk_done)));

    p_tmo_from_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> ($past(state_q) == ST_WAIT && !$past(blk_done)));
endmodule

// File: tb/test_i2c_tag_streamer.sv
// Directed bench for i2c_tag_streamer: one task per scenario, each comparing
// the output word stream against a model built from the requirements.
module test_i2c_tag_streamer;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [9:0]        req_addr = '0;
    logic              req_rd = 1'b0;
    logic              req_ten = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              din_valid = 1'b0;
    logic [7:0]        din_byte = '0;
    logic              din_ready;
    logic              out_valid;
    logic [31:0]       out_data;
    logic              out_ready = 1'b1;
    logic [LEN_W:0]    entry_cnt;
    logic              entry_cnt_valid;
    logic              blk_done = 1'b0;
    logic [15:0]       tmo_limit = 16'd1000;
    logic              busy, xfer_done, len_err, timeout;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_words[$];
    int          blk_nw[$];
    int          exp_entries;

    i2c_tag_streamer i_i2c_tag_streamer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_rd(req_rd), .req_ten(req_ten), .req_len(req_len),
        .din_valid(din_valid), .din_byte(din_byte), .din_ready(din_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .entry_cnt(entry_cnt), .entry_cnt_valid(entry_cnt_valid),
        .blk_done(blk_done), .tmo_limit(tmo_limit), .busy(busy),
        .xfer_done(xfer_done), .len_err(len_err), .timeout(timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    // Model: expected words per block from the requirements.
    task automatic build_exp(input logic [9:0] addr, input bit rd, input bit ten,
                             input int len);
        int nblk;
        logic [10:0] a;
        exp_words.delete();
        blk_nw.delete();
        nblk = (len + 255) / 256;
        exp_entries = len + 4 + 2 * (nblk - 1);
        a = {addr, rd};
        for (int b = 0; b < nblk; b++) begin
            logic [7:0] q[$];
            int rem = len - b * 256;
            int blen = (rem > 256) ? 256 : rem;
            bit lst = (b == nblk - 1);
            int nw;
            if (b == 0) begin
                q.push_back(8'h81);
                q.push_back(a[7:0]);
                if (ten) q.push_back({5'b0, a[10:8]});
            end
            q.push_back(rd ? (lst ? 8'h87 : 8'h85) : (lst ? 8'h83 : 8'h82));
            q.push_back(8'(blen & 255));
            if (!rd) for (int j = 0; j < blen; j++) q.push_back(pay(b * 256 + j));
            nw = (q.size() + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                logic [31:0] wd = '0;
                for (int k = 0; k < 4; k++)
                    if (w * 4 + k < q.size()) wd[8*k +: 8] = q[w * 4 + k];
                exp_words.push_back(wd);
            end
            blk_nw.push_back(nw);
        end
    endtask

    // Drive one transfer and check words, count and block sequencing.
    task automatic run_xfer(input logic [9:0] addr, input bit rd, input bit ten,
                            input int len, input bit stall, input bit early_done,
                            input bit skip_done, input string req);
        int wi = 0;
        int pk = 0;
        build_exp(addr, rd, ten, len);
        @(negedge clk);
        req_addr = addr; req_rd = rd; req_ten = ten; req_len = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(entry_cnt_valid == 1'b1, "R3", "entry strobe", entry_cnt_valid, 1);
        chk(entry_cnt == (LEN_W+1)'(exp_entries), "R3", "entry count", entry_cnt, exp_entries);
        for (int b = 0; b < blk_nw.size(); b++) begin
            int got = 0;
            int cyc = 0;
            bit held = 0;
            logic [31:0] held_d = '0;
            while (got < blk_nw[b]) begin
                out_ready = stall ? (cyc % 3 != 0) : 1'b1;
                din_valid = !rd;
                din_byte  = pay(pk);
                blk_done  = early_done && (cyc == 1);
                #1;
                if (held)
                    chk(out_valid && out_data == held_d, "R9", "stall hold", out_data, held_d);
                held = out_valid && !out_ready;
                held_d = out_data;
                if (out_valid && out_ready) begin
                    chk(out_data == exp_words[wi], req, $sformatf("word %0d", wi),
                        out_data, exp_words[wi]);
                    wi++;
                    got++;
                end
                if (din_ready && rd) chk(0, "R7", "din_ready on read", 1, 0);
                if (din_ready && din_valid) pk++;
                @(negedge clk);
                cyc++;
            end
            out_ready = 1'b1; din_valid = 1'b0; blk_done = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!out_valid, "R10", "no word before blk_done", out_valid, 0);
            end
            if (skip_done) return;
            blk_done = 1'b1;
            @(negedge clk);
            blk_done = 1'b0;
            if (b == blk_nw.size() - 1) begin
                chk(xfer_done == 1'b1, "R10", "xfer_done", xfer_done, 1);
                chk(req_ready == 1'b1, "R10", "idle after final", req_ready, 1);
            end
        end
        chk(pk == (rd ? 0 : len), "R7", "payload bytes taken", pk, rd ? 0 : len);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(!out_valid, "R1", "out_valid", out_valid, 0);
        chk(!din_ready, "R1", "din_ready", din_ready, 0);
        chk(!busy, "R1", "busy", busy, 0);
    endtask

    task automatic t_zero_len;
        @(negedge clk);
        req_len = '0; req_rd = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(len_err == 1'b1, "R2", "len_err", len_err, 1);
        chk(!entry_cnt_valid, "R2", "no count", entry_cnt_valid, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!out_valid && !busy, "R2", "stays idle", {out_valid, busy}, 0);
        end
    endtask

    task automatic t_timeout;
        int n = 0;
        bit seen = 0;
        tmo_limit = 16'd5;
        run_xfer(10'h33, 1'b0, 1'b0, 3, 1'b0, 1'b0, 1'b1, "R8");
        // 3 negedges already passed after the last word
        n = 3;
        while (n < 30 && !seen) begin
            @(negedge clk);
            n++;
            if (timeout) seen = 1;
        end
        chk(seen, "R11", "timeout seen", seen, 1);
        chk(n >= 7 && n <= 10, "R11", "timeout cycle", n, 8);
        chk(req_ready && !busy, "R11", "idle after timeout", req_ready, 1);
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!out_valid && !xfer_done && !busy, "R11", "late blk_done ignored",
                {out_valid, xfer_done, busy}, 0);
        end
        tmo_limit = 16'd1000;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R4 R5 R6 R8: short write, seven-bit address
        run_xfer(10'h050, 1'b0, 1'b0, 5, 1'b0, 1'b0, 1'b0, "R4/R5/R6/R8");
        // R4: ten-bit read address, single byte
        run_xfer(10'h2A5, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R4/R5/R6");
        // R5 R6 R9 R10: long write with stalls and an early blk_done
        run_xfer(10'h011, 1'b0, 1'b0, 600, 1'b1, 1'b1, 1'b0, "R5/R6/R7/R8");
        // R5 R6: multi-block read ending in a one-byte block
        run_xfer(10'h07F, 1'b1, 1'b0, 513, 1'b0, 1'b0, 1'b0, "R5/R6");
        // R6: exactly one full block read, length byte 0x00
        run_xfer(10'h3FF, 1'b1, 1'b1, 256, 1'b1, 1'b0, 1'b0, "R4/R6");
        t_zero_len();
        t_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule